// File: doc/BRIEF.md
# External Master Slave-Access Timing Controller

This block lets a bus master outside the chip read and write an on-chip RAM and register area. To that master the area is a bus slave. The master drives an active-low chip select, an active-low address strobe, a read/write line (1 = read) and two active-low byte-lane data strobes. The block turns each access into a single request on a simple RAM port. It then answers with an active-low transfer acknowledge, whose timing depends on the access mode in force.

There are two access modes. In asynchronous mode the strobes may change at any time relative to the local clock. Each strobe passes through a two-flop synchronizer, and the acknowledge follows after three wait states. In synchronous mode the master promises that its strobes are timed to the local clock, so the block samples them directly. A synchronous access is then acknowledged on the first clock. Reads take one extra wait state when the extra-wait bit is set.

Both mode bits sit in a small configuration register. That register lives at the top word address of the slave space and is reached through the same port. Each access is acknowledged under the mode that was in force when it began.

Top module: `xm_slave_ctrl`

## Requirements
- R1: After reset the acknowledge is negated, both configuration bits read as 0, and accesses use asynchronous timing.
- R2: In asynchronous mode, every read and write drives `dtack_n` low after the 6th rising clock edge following strobe assertion: two synchronizer stages, one start edge and three wait states.
- R3: In synchronous mode with the extra-wait bit clear, reads and writes drive `dtack_n` low after the 1st rising edge following strobe assertion.
- R4: In synchronous mode with the extra-wait bit set, reads drive `dtack_n` low after the 2nd rising edge. Writes still do so after the 1st.
- R5: `dtack_n` stays low while the strobes stay asserted. After the strobes are negated it rises at once in synchronous mode, and after the 2nd rising edge in asynchronous mode.
- R6: While `cs_n` is high, `dtack_n` stays high and `mem_req` stays low, whatever the strobes do.
- R7: The configuration register sits at word address all-ones. Bit 0 = 1 selects synchronous mode and bit 1 = 1 enables the extra read wait. It is written through the low byte lane (`lds_n` low) and reads back in bits [1:0] with zeros above.
- R8: A mode change takes effect from the next access. The write that changes the mode is acknowledged with the timing of the old mode.
- R9: A RAM access drives `mem_addr`, `mem_we` (= not read), `mem_be` ({upper lane, lower lane}, from `uds_n` and `lds_n`) and `mem_wdata`. On a read, the word on `mem_rdata` is presented on `rdata` while the acknowledge is asserted.
- R10: `mem_req` is high for exactly one cycle for each RAM access and never for a configuration register access. It is never high while `dtack_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| uds_n | input | 1 | Upper byte lane strobe, active low |
| lds_n | input | 1 | Lower byte lane strobe, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data from the master |
| rdata | output | DW | Read data to the master |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| mem_req | output | 1 | One-cycle RAM access request |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM word address |
| mem_be | output | 2 | RAM byte enables {upper, lower} |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, valid in the same cycle as the address |

## Verification
The hardest case to reach from the ports is the access that rewrites the mode bit itself. Its acknowledge and its release must still follow the old mode, even though the register has already changed by then. The stimulus table places configuration writes that switch the mode in both directions. Each write is followed directly by an access whose expected wait count and release delay belong to the new mode. Every access also holds its strobes for several cycles past the acknowledge, so that the hold behaviour and the release delay are measured each time.

// File: rtl/xm_pkg.sv
package xm_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_ACK  = 2'd2
    } seq_state_e;

    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } acc_mode_e;

    // bit 1: extra read wait, bit 0: access mode
    typedef struct packed {
        logic      xwait;
        acc_mode_e mode;
    } cfg_t;

    localparam int ASYNC_WAITS = 3;
    localparam int SYNC_RD_XW  = 1;
    localparam int WAIT_W      = $clog2(ASYNC_WAITS + 1);

    function automatic logic [WAIT_W-1:0] waits_for(input cfg_t c, input logic is_read);
        logic [WAIT_W-1:0] n;
        if (c.mode == MODE_ASYNC)
            n = WAIT_W'(ASYNC_WAITS);
        else if (is_read && c.xwait)
            n = WAIT_W'(SYNC_RD_XW);
        else
            n = '0;
        return n;
    endfunction

endpackage

// File: rtl/xm_sync.sv
module xm_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= '0;
            else if (s == 0)
                chain[s] <= d;
            else
                chain[s] <= chain[(s == 0) ? 0 : s - 1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xm_cfg_reg.sv
module xm_cfg_reg
    import xm_pkg::*;
#(
    parameter int             AW       = 8,
    parameter logic [AW-1:0]  CFG_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          lane_lo,
    input  logic [1:0]    wbits,
    output logic          hit,
    output cfg_t          cfg
);
    assign hit = (addr == CFG_ADDR);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '{xwait: 1'b0, mode: MODE_ASYNC};
        else if (wr_en && hit && lane_lo)
            cfg <= cfg_t'(wbits);
    end
endmodule

// File: rtl/xm_wait_seq.sv
module xm_wait_seq
    import xm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_raw,
    input  logic req_sync,
    input  cfg_t cfg,
    input  logic is_read,
    output logic start,
    output logic ack
);
    seq_state_e        state;
    acc_mode_e         mode_q;
    logic [WAIT_W-1:0] cnt;
    acc_mode_e         mode_eff;
    logic              req_eff;
    logic [WAIT_W-1:0] n_wait;

    // the mode is frozen at the start edge of each access
    assign mode_eff = (state == SQ_IDLE) ? cfg.mode : mode_q;
    assign req_eff  = (mode_eff == MODE_SYNC) ? req_raw : req_sync;
    assign start    = (state == SQ_IDLE) && req_eff;
    assign ack      = (state == SQ_ACK) && req_eff;
    assign n_wait   = waits_for(cfg, is_read);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            mode_q <= MODE_ASYNC;
            cnt    <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        mode_q <= cfg.mode;
                        cnt    <= n_wait;
                        state  <= (n_wait == '0) ? SQ_ACK : SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (!req_eff)
                        state <= SQ_IDLE;
                    else if (cnt == WAIT_W'(1))
                        state <= SQ_ACK;
                    cnt <= cnt - WAIT_W'(1);
                end
                SQ_ACK: begin
                    if (!req_eff)
                        state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xm_slave_ctrl.sv
module xm_slave_ctrl
    import xm_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 16,
    parameter logic [AW-1:0] CFG_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          as_n,
    input  logic          rw,
    input  logic          uds_n,
    input  logic          lds_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          dtack_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int NSTB = 3;

    logic [NSTB-1:0] stb_raw;
    logic [NSTB-1:0] stb_syn;
    logic            req_raw;
    logic            req_sync;
    logic            start;
    logic            ack;
    logic            cfg_hit;
    cfg_t            cfg_q;
    logic [DW-1:0]   rdata_q;

    // {address strobe, upper lane, lower lane}, active high
    assign stb_raw  = {~as_n, ~uds_n, ~lds_n};
    assign req_raw  = ~cs_n & stb_raw[2] & (stb_raw[1] | stb_raw[0]);
    assign req_sync = ~cs_n & stb_syn[2] & (stb_syn[1] | stb_syn[0]);

    xm_sync #(.W(NSTB), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (stb_raw),
        .q   (stb_syn)
    );

    xm_wait_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_raw  (req_raw),
        .req_sync (req_sync),
        .cfg      (cfg_q),
        .is_read  (rw),
        .start    (start),
        .ack      (ack)
    );

    xm_cfg_reg #(.AW(AW), .CFG_ADDR(CFG_ADDR)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (start & ~rw),
        .lane_lo (~lds_n),
        .wbits   (wdata[1:0]),
        .hit     (cfg_hit),
        .cfg     (cfg_q)
    );

    assign mem_req   = start & ~cfg_hit;
    assign mem_we    = ~rw;
    assign mem_addr  = addr;
    assign mem_be    = {~uds_n, ~lds_n};
    assign mem_wdata = wdata;

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (start && rw)
            rdata_q <= cfg_hit ? {{(DW-2){1'b0}}, cfg_q} : mem_rdata;
    end

    assign rdata   = rdata_q;
    assign dtack_n = ~ack;
endmodule

// File: rtl/xm_slave_ctrl_chk.sv
module xm_slave_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rw,
    input logic       lds_n,
    input logic       dtack_n,
    input logic       mem_req,
    input logic [1:0] cfg_bits
);
    AST_RESET_NO_ACK: assert property (@(posedge clk) rst |=> dtack_n); // R1
    AST_NO_ACK_UNSELECTED: assert property (@(posedge clk) disable iff (rst) cs_n |-> dtack_n); // R6
    AST_NO_REQ_UNSELECTED: assert property (@(posedge clk) disable iff (rst) mem_req |-> !cs_n); // R6
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R10
    AST_REQ_NOT_IN_ACK: assert property (@(posedge clk) disable iff (rst) mem_req |-> dtack_n); // R10
    AST_CFG_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(cfg_bits)) |-> $past(!cs_n && !rw && !lds_n)); // R7
endmodule

bind xm_slave_ctrl xm_slave_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rw       (rw),
    .lds_n    (lds_n),
    .dtack_n  (dtack_n),
    .mem_req  (mem_req),
    .cfg_bits (cfg_q)
);

// File: tb/xm_slave_ctrl_tb.sv
module xm_slave_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, as_n = 1'b1, rw = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic dtack_n, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0] mem_be;
    logic [DW-1:0] mem_wdata, mem_rdata;

    int n_total = 0;
    int n_fail  = 0;
    int reqcnt  = 0;

    always #5 clk = ~clk;

    xm_slave_ctrl #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .as_n(as_n), .rw(rw),
        .uds_n(uds_n), .lds_n(lds_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dtack_n(dtack_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // attached RAM model, read in the same cycle
    logic [DW-1:0] ram [256];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) ram[i] <= '0;
        end else if (mem_req && mem_we) begin
            if (mem_be[1]) ram[mem_addr][15:8] <= mem_wdata[15:8];
            if (mem_be[0]) ram[mem_addr][7:0]  <= mem_wdata[7:0];
        end
    end
    assign mem_rdata = ram[mem_addr];

    always @(posedge clk) if (!rst && mem_req) reqcnt++;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        rd;
        logic [7:0]  adr;
        logic [1:0]  lanes;
        logic [15:0] data;
        logic [3:0]  lat;
        logic [3:0]  rel;
        logic        req;
    } vec_t;

    // cfg word address 0xFF: bit0 sync mode, bit1 extra read wait
    localparam vec_t TBL [12] = '{
        '{1'b0, 8'h10, 2'b11, 16'hA5A5, 4'd6, 4'd2, 1'b1},  // R2 async write
        '{1'b1, 8'h10, 2'b11, 16'hA5A5, 4'd6, 4'd2, 1'b1},  // R2 async read
        '{1'b0, 8'hFF, 2'b01, 16'h0001, 4'd6, 4'd2, 1'b0},  // R8 set sync, old timing
        '{1'b1, 8'h10, 2'b11, 16'hA5A5, 4'd1, 4'd0, 1'b1},  // R3 sync read
        '{1'b0, 8'h20, 2'b10, 16'h1234, 4'd1, 4'd0, 1'b1},  // R9 upper lane only
        '{1'b1, 8'h20, 2'b11, 16'h1200, 4'd1, 4'd0, 1'b1},  // R9 lane merge
        '{1'b0, 8'hFF, 2'b01, 16'h0003, 4'd1, 4'd0, 1'b0},  // R7 extra wait on
        '{1'b1, 8'h20, 2'b11, 16'h1200, 4'd2, 4'd0, 1'b1},  // R4 read + wait
        '{1'b0, 8'h21, 2'b11, 16'hBEEF, 4'd1, 4'd0, 1'b1},  // R4 write no wait
        '{1'b1, 8'hFF, 2'b11, 16'h0003, 4'd2, 4'd0, 1'b0},  // R7 cfg readback
        '{1'b0, 8'hFF, 2'b01, 16'h0000, 4'd1, 4'd0, 1'b0},  // R8 back to async, sync timing
        '{1'b1, 8'hFF, 2'b11, 16'h0000, 4'd6, 4'd2, 1'b0}   // R8 async again
    };

    task automatic access(input vec_t v, input string tag);
        int n;
        int m;
        int r0;
        logic got;
        r0 = reqcnt;
        @(negedge clk);
        cs_n = 1'b0; rw = v.rd; addr = v.adr; wdata = v.rd ? 16'h0 : v.data;
        as_n = 1'b0; uds_n = ~v.lanes[1]; lds_n = ~v.lanes[0];
        n = 0; got = 1'b0;
        while (!got && n < 20) begin
            @(posedge clk); #1; n++;
            if (!dtack_n) got = 1'b1;
        end
        check(n == int'(v.lat), {tag, " ack latency R2 R3 R4"}, n, int'(v.lat));
        if (v.rd) check(rdata == v.data, {tag, " read data R9 R7"}, int'(rdata), int'(v.data));
        repeat (3) @(posedge clk);
        #1 check(dtack_n == 1'b0, {tag, " ack held R5"}, int'(dtack_n), 0);
        @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        #1; m = 0;
        while (!dtack_n && m < 20) begin
            @(posedge clk); #1; m++;
        end
        cs_n = 1'b1;
        check(m == int'(v.rel), {tag, " release delay R5"}, m, int'(v.rel));
        repeat (3) @(negedge clk);
        check(reqcnt - r0 == int'(v.req), {tag, " request count R10"}, reqcnt - r0, int'(v.req));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int lows;
        int r0;
        repeat (3) @(posedge clk);
        #1 check(dtack_n == 1'b1, "R1 ack negated in reset", int'(dtack_n), 1);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(dtack_n == 1'b1, "R1 ack negated after reset", int'(dtack_n), 1);
        // R1: cfg reads zero with asynchronous timing
        access('{1'b1, 8'hFF, 2'b11, 16'h0000, 4'd6, 4'd2, 1'b0}, "R1 reset cfg");

        for (int i = 0; i < 12; i++) access(TBL[i], $sformatf("vec%0d", i));

        // R6: strobes active while not selected
        r0 = reqcnt; lows = 0;
        @(negedge clk);
        cs_n = 1'b1; rw = 1'b1; addr = 8'h10; as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #1;
            if (!dtack_n) lows++;
        end
        check(lows == 0, "R6 no ack unselected", lows, 0);
        check(reqcnt == r0, "R6 no request unselected", reqcnt - r0, 0);
        @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6: same in synchronous mode
        access('{1'b0, 8'hFF, 2'b01, 16'h0001, 4'd6, 4'd2, 1'b0}, "R6 set sync");
        r0 = reqcnt; lows = 0;
        @(negedge clk);
        cs_n = 1'b1; rw = 1'b0; addr = 8'h30; wdata = 16'h5555;
        as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            if (!dtack_n) lows++;
        end
        check(lows == 0, "R6 no ack unselected sync", lows, 0);
        check(reqcnt == r0, "R6 no request unselected sync", reqcnt - r0, 0);
        @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        repeat (2) @(negedge clk);
        // R6: the ignored write left the location untouched
        access('{1'b1, 8'h30, 2'b11, 16'h0000, 4'd1, 4'd0, 1'b1}, "R6 location untouched");

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule